// File: doc/BRIEF.md
# Timer Interrupt Flag Register Unit

This unit keeps the interrupt status of a 16-bit timer/counter. It holds four sticky flags: overflow, compare match A, compare match B and input capture. Each flag is set by a strobe from the timer and raises an interrupt request when its enable is high. A flag is cleared when the interrupt controller acknowledges its vector, or when software writes a one to the flag's bit. A second register holds a synchronisation-mode bit and a prescaler-reset bit, and drives the prescaler reset line.

Software reaches both registers through a small port. Writes are synchronous and reads are combinational. The flag register is at address 0 and the control register is at address 1. The timer supplies raw strobes: counter-equals-compare per channel, forced-compare strobes, a timer clock enable (`tmr_tick`), overflow, capture-pin events, counter-at-TOP, and a mode line that says whether the capture register is TOP. Per-flag vectors `vec_ack`, `irq_en` and `irq` use the index order 0 = overflow, 1 = compare A, 2 = compare B, 3 = input capture.

Top module: `tmr_flag_regs`

## Requirements
- R1: After reset both registers read 0x00, and `irq` and `prescaler_rst` are 0.
- R2: The flag register (address 0) shows input capture at bit 5, compare B at bit 2, compare A at bit 1 and overflow at bit 0. Bits 7:6 and 4:3 always read 0. The control register (address 1) shows sync mode at bit 7 and prescaler reset at bit 0, and bits 6:1 read 0.
- R3: When `top_is_icr` is 0, a `capt_evt` pulse sets the capture flag and `cnt_at_top` is ignored. When `top_is_icr` is 1, `cnt_at_top` sets the capture flag and `capt_evt` is ignored. The flag reads set one clock after the strobe.
- R4: A compare flag sets on the next timer tick after the tick on which its equality input was high, and not before. With `tmr_tick` held high, the flag reads set two clocks after the match.
- R5: A match sampled on a tick on which the channel's forced-compare strobe is also high never sets that compare flag.
- R6: An `ovf_evt` pulse sets the overflow flag, which reads set one clock later.
- R7: A high `vec_ack` bit clears its flag on the next clock and leaves the other flags alone.
- R8: Writing the flag register clears each flag whose data bit is 1. Flags written with 0 keep their value.
- R9: If a set strobe and a clear (acknowledge or write-one) hit the same flag in the same cycle, the flag ends up set.
- R10: Each `irq` bit equals its flag AND its `irq_en` bit.
- R11: While sync mode is 1, a prescaler-reset bit written as 1 is kept, and `prescaler_rst` stays high until software writes it to 0.
- R12: While sync mode is 0, writing prescaler reset as 1 makes `prescaler_rst` high for exactly one clock. The bit then clears by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address (0 flags, 1 control) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data |
| tmr_tick | input | 1 | Timer clock enable |
| cmpa_eq | input | 1 | Counter equals compare A |
| cmpb_eq | input | 1 | Counter equals compare B |
| force_a | input | 1 | Forced compare strobe, channel A |
| force_b | input | 1 | Forced compare strobe, channel B |
| ovf_evt | input | 1 | Overflow event for the current mode |
| capt_evt | input | 1 | Capture pin event |
| cnt_at_top | input | 1 | Counter reached TOP |
| top_is_icr | input | 1 | Mode uses capture register as TOP |
| vec_ack | input | 4 | Per-flag vector acknowledge |
| irq_en | input | 4 | Per-flag interrupt enable |
| irq | output | 4 | Per-flag interrupt request |
| prescaler_rst | output | 1 | Prescaler reset |

## Verification
Overflow and capture flags, acknowledge clears, write-one clears and control writes take effect on the first clock edge after the stimulus. The bench drives each stimulus on a falling edge and reads on the next falling edge. Compare flags need two timer ticks. The bench checks at the falling edge after the first tick that the flag is still clear, and checks it set only after the second tick. With ticks held off in between, it checks that nothing changes until the next tick. The prescaler pulse is read on the falling edge after the write and again one clock later, to show it lasts exactly one cycle. `irq` is combinational from the flags and is read in the same half-cycle as the flag register.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
   localparam int NUM_FLAGS     = 4;
   localparam int CTRL_SYNC_BIT = 7;
   localparam int CTRL_PSR_BIT  = 0;

   typedef enum logic [1:0] {
      FL_TOV = 2'd0,
      FL_OCA = 2'd1,
      FL_OCB = 2'd2,
      FL_ICF = 2'd3
   } flag_idx_e;

   // bit position of each flag inside the flag register
   function automatic int flag_bit(input int idx);
      case (idx)
         0:       return 0;
         1:       return 1;
         2:       return 2;
         default: return 5;
      endcase
   endfunction
endpackage

// File: rtl/tfr_flag_cell.sv
module tfr_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   // set dominates clear so a coincident event is never lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set_i | (flag_q & ~clr_i);
   end

   assign flag_o = flag_q;

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
   a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_q);
   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/tfr_cmp_qual.sv
module tfr_cmp_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic eq_i,
   input  logic force_i,
   output logic set_o
);
   logic pend_q;

   // a match seen on one tick is reported on the following tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (tick_i) pend_q <= eq_i & ~force_i;
   end

   assign set_o = tick_i & pend_q;

   a_r5_force_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && force_i) |=> !pend_q);
   a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(pend_q));
endmodule

// File: rtl/tfr_sync_ctl.sv
module tfr_sync_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic sync_d,
   input  logic psr_d,
   output logic sync_o,
   output logic psr_o
);
   logic sync_q, psr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         psr_q  <= 1'b0;
      end else if (wr_i) begin
         sync_q <= sync_d;
         psr_q  <= psr_d;
      end else if (!sync_q) begin
         psr_q  <= 1'b0;
      end
   end

   assign sync_o = sync_q;
   assign psr_o  = psr_q;

   a_r12_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_q && !wr_i) |=> !psr_q);
   a_r11_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_q && !wr_i) |=> $stable(psr_q));
endmodule

// File: rtl/tmr_flag_regs.sv
module tmr_flag_regs #(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8,
   parameter int FLAG_ADDR   = 0,
   parameter int CTRL_ADDR   = 1,
   parameter bit CAPT_TOP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tmr_tick,
   input  logic              cmpa_eq,
   input  logic              cmpb_eq,
   input  logic              force_a,
   input  logic              force_b,
   input  logic              ovf_evt,
   input  logic              capt_evt,
   input  logic              cnt_at_top,
   input  logic              top_is_icr,
   input  logic [3:0]        vec_ack,
   input  logic [3:0]        irq_en,
   output logic [3:0]        irq,
   output logic              prescaler_rst
);
   import tfr_pkg::*;

   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

   if (DATA_W < 8) begin : g_bad_width
      $error("tmr_flag_regs: DATA_W must be at least 8");
   end
   if (FLAG_ADDR == CTRL_ADDR) begin : g_bad_addr
      $error("tmr_flag_regs: register addresses must differ");
   end
   if (FLAG_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("tmr_flag_regs: address out of range");
   end

   logic wr_flags, wr_ctrl;
   assign wr_flags = reg_wr && (reg_addr == A_FLAG);
   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);

   logic [NUM_FLAGS-1:0] set_v, clr_v, flag_v;
   logic sync_q;

   // overflow event arrives already qualified by the waveform mode
   assign set_v[FL_TOV] = ovf_evt;

   tfr_cmp_qual u_qual_a (
      .clk(clk), .rst_n(rst_n), .tick_i(tmr_tick),
      .eq_i(cmpa_eq), .force_i(force_a), .set_o(set_v[FL_OCA]));

   tfr_cmp_qual u_qual_b (
      .clk(clk), .rst_n(rst_n), .tick_i(tmr_tick),
      .eq_i(cmpb_eq), .force_i(force_b), .set_o(set_v[FL_OCB]));

   if (CAPT_TOP_EN) begin : g_capt_mux
      assign set_v[FL_ICF] = top_is_icr ? cnt_at_top : capt_evt;
   end else begin : g_capt_pin
      logic unused_top;
      assign unused_top    = top_is_icr ^ cnt_at_top;
      assign set_v[FL_ICF] = capt_evt;
   end

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      localparam int BP = flag_bit(g);
      assign clr_v[g] = vec_ack[g] | (wr_flags & reg_wdata[BP]);
      tfr_flag_cell u_cell (
         .clk(clk), .rst_n(rst_n), .set_i(set_v[g]),
         .clr_i(clr_v[g]), .flag_o(flag_v[g]));
   end

   assign irq = flag_v & irq_en;

   tfr_sync_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl),
      .sync_d(reg_wdata[CTRL_SYNC_BIT]), .psr_d(reg_wdata[CTRL_PSR_BIT]),
      .sync_o(sync_q), .psr_o(prescaler_rst));

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_FLAG) begin
         for (int i = 0; i < NUM_FLAGS; i++) reg_rdata[flag_bit(i)] = flag_v[i];
      end else if (reg_addr == A_CTRL) begin
         reg_rdata[CTRL_SYNC_BIT] = sync_q;
         reg_rdata[CTRL_PSR_BIT]  = prescaler_rst;
      end
   end

   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_FLAG) |-> (reg_rdata[7:6] == 2'b00 && reg_rdata[4:3] == 2'b00));
   a_r3_top_ignores_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (top_is_icr && capt_evt && !cnt_at_top && !flag_v[FL_ICF]) |=> !flag_v[FL_ICF]);
   a_r6_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> flag_v[FL_TOV]);
endmodule

// File: tb/tmr_flag_regs_bench.sv
module tmr_flag_regs_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic tmr_tick = 1'b1, cmpa_eq = 0, cmpb_eq = 0, force_a = 0, force_b = 0;
   logic ovf_evt = 0, capt_evt = 0, cnt_at_top = 0, top_is_icr = 0;
   logic [3:0] vec_ack = '0, irq_en = '0, irq;
   logic prescaler_rst;

   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tmr_flag_regs u_tmr_flag_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_tick(tmr_tick),
      .cmpa_eq(cmpa_eq), .cmpb_eq(cmpb_eq), .force_a(force_a), .force_b(force_b),
      .ovf_evt(ovf_evt), .capt_evt(capt_evt), .cnt_at_top(cnt_at_top),
      .top_is_icr(top_is_icr), .vec_ack(vec_ack), .irq_en(irq_en), .irq(irq),
      .prescaler_rst(prescaler_rst));

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic clear_all();
      wr(2'd0, 8'h27);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(2'd0, d); chk("R1 flags", d, 8'h00);
      rd(2'd1, d); chk("R1 ctrl", d, 8'h00);
      chk("R1 irq", {4'h0, irq}, 8'h00);
      chk("R1 psr", {7'h0, prescaler_rst}, 8'h00);
   endtask

   task automatic t_overflow();
      logic [7:0] d;
      @(negedge clk); ovf_evt = 1;
      @(negedge clk); ovf_evt = 0;
      rd(2'd0, d); chk("R6 ovf set", d, 8'h01);
      chk("R2 ovf bit0", d & 8'hD8, 8'h00);
      clear_all();
   endtask

   task automatic t_capture();
      logic [7:0] d;
      top_is_icr = 0;
      @(negedge clk); cnt_at_top = 1;
      @(negedge clk); cnt_at_top = 0;
      rd(2'd0, d); chk("R3 top ignored", d, 8'h00);
      capt_evt = 1;
      @(negedge clk); capt_evt = 0;
      rd(2'd0, d); chk("R3 pin sets bit5 (R2)", d, 8'h20);
      clear_all();
      top_is_icr = 1;
      @(negedge clk); capt_evt = 1;
      @(negedge clk); capt_evt = 0;
      rd(2'd0, d); chk("R3 pin ignored", d, 8'h00);
      cnt_at_top = 1;
      @(negedge clk); cnt_at_top = 0;
      rd(2'd0, d); chk("R3 top sets", d, 8'h20);
      top_is_icr = 0;
      clear_all();
   endtask

   task automatic t_compare();
      logic [7:0] d;
      @(negedge clk); cmpa_eq = 1;
      @(negedge clk); cmpa_eq = 0;
      rd(2'd0, d); chk("R4 not yet A", d, 8'h00);
      @(negedge clk);
      rd(2'd0, d); chk("R4 A set bit1", d, 8'h02);
      clear_all();
      cmpb_eq = 1;
      @(negedge clk); cmpb_eq = 0; tmr_tick = 0;
      repeat (3) @(negedge clk);
      rd(2'd0, d); chk("R4 wait tick B", d, 8'h00);
      tmr_tick = 1;
      @(negedge clk);
      rd(2'd0, d); chk("R4 B set bit2", d, 8'h04);
      clear_all();
   endtask

   task automatic t_force();
      logic [7:0] d;
      @(negedge clk); cmpa_eq = 1; force_a = 1; cmpb_eq = 1; force_b = 1;
      @(negedge clk); cmpa_eq = 0; force_a = 0; cmpb_eq = 0; force_b = 0;
      repeat (2) @(negedge clk);
      rd(2'd0, d); chk("R5 forced no flag", d, 8'h00);
   endtask

   task automatic t_ack();
      logic [7:0] d;
      @(negedge clk); ovf_evt = 1; capt_evt = 1;
      @(negedge clk); ovf_evt = 0; capt_evt = 0; vec_ack = 4'b1000;
      @(negedge clk); vec_ack = 0;
      rd(2'd0, d); chk("R7 ack icf only", d, 8'h01);
      vec_ack = 4'b0001;
      @(negedge clk); vec_ack = 0;
      rd(2'd0, d); chk("R7 ack ovf", d, 8'h00);
   endtask

   task automatic t_w1c();
      logic [7:0] d;
      @(negedge clk); ovf_evt = 1; capt_evt = 1;
      @(negedge clk); ovf_evt = 0; capt_evt = 0;
      wr(2'd0, 8'h00);
      rd(2'd0, d); chk("R8 zero keeps", d, 8'h21);
      wr(2'd0, 8'h20);
      rd(2'd0, d); chk("R8 one clears", d, 8'h01);
      clear_all();
   endtask

   task automatic t_priority();
      logic [7:0] d;
      @(negedge clk); ovf_evt = 1;
      @(negedge clk); vec_ack = 4'b0001;
      @(negedge clk); ovf_evt = 0; vec_ack = 0;
      rd(2'd0, d); chk("R9 ack vs set", d, 8'h01);
      capt_evt = 1; reg_addr = 2'd0; reg_wdata = 8'h20; reg_wr = 1;
      @(negedge clk); capt_evt = 0; reg_wr = 0; reg_wdata = 0;
      rd(2'd0, d); chk("R9 w1c vs set", d, 8'h21);
      clear_all();
   endtask

   task automatic t_irq();
      logic [7:0] d;
      @(negedge clk); ovf_evt = 1; capt_evt = 1;
      @(negedge clk); ovf_evt = 0; capt_evt = 0;
      irq_en = 4'b0000; #1 chk("R10 masked", {4'h0, irq}, 8'h00);
      irq_en = 4'b1001; #1 chk("R10 both", {4'h0, irq}, 8'h09);
      irq_en = 4'b0110; #1 chk("R10 no flags", {4'h0, irq}, 8'h00);
      irq_en = 4'b1000; #1 chk("R10 icf", {4'h0, irq}, 8'h08);
      irq_en = 0;
      clear_all();
      rd(2'd0, d); chk("R8 all cleared", d, 8'h00);
   endtask

   task automatic t_sync();
      logic [7:0] d;
      wr(2'd1, 8'h81);
      rd(2'd1, d); chk("R11 ctrl read (R2)", d, 8'h81);
      repeat (3) @(negedge clk);
      chk("R11 psr held", {7'h0, prescaler_rst}, 8'h01);
      wr(2'd1, 8'h80);
      rd(2'd1, d); chk("R11 psr off", d, 8'h80);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_pulse();
      logic [7:0] d;
      wr(2'd1, 8'h01);
      chk("R12 pulse high", {7'h0, prescaler_rst}, 8'h01);
      @(negedge clk);
      chk("R12 pulse gone", {7'h0, prescaler_rst}, 8'h00);
      rd(2'd1, d); chk("R12 ctrl zero", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_overflow();
      t_capture();
      t_compare();
      t_force();
      t_ack();
      t_w1c();
      t_priority();
      t_irq();
      t_sync();
      t_pulse();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule